// File: doc/BRIEF.md
# Reloading Down-Count Timer with Prescaler

This block is an 8-bit down-counting timer with a preload buffer. A prescaler divides the system clock and produces the count ticks. While the timer runs, each tick lowers the count by one. A tick that finds the count at zero is an underflow, the step from 00h to FFh. An underflow reloads the count from the buffer, sets a sticky underflow flag, and raises a one-cycle interrupt request if the interrupt enable input is high. One timer period is therefore (buffer + 1) ticks.

Software reaches the timer through a small synchronous register port with two addresses. Address 0 is the counting register. A write to it updates the preload buffer. If the timer is stopped, the same write also sets the live count. A read returns the live count, not the buffer. Address 1 is the control word. It holds the run bit, the underflow flag and the prescaler select. Starting the timer copies the buffer into the counter and begins a full first prescaler period.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the count, buffer, run bit, flag and prescaler select are all 0, and `irq` is low.
- R2: While running, the count drops by exactly one on each prescaler tick and holds between ticks.
- R3: The select field (control bits 2:0) sets the tick period. Codes 000, 001, 010 and 011 give 1, 2, 4 and 8 clocks. Any code with bit 2 set gives 16 clocks.
- R4: A tick that finds the count at 0 reloads it from the buffer and sets the flag. A buffer written during a period sets the length of the next period.
- R5: On each underflow, `irq` is high for exactly one cycle if `irq_en` was high. Otherwise `irq` stays low.
- R6: Writing 1 to the run bit (control bit 7) while stopped loads the buffer into the count. The first decrement then comes one full prescaler period later.
- R7: A write to address 0 while stopped sets both the buffer and the count. While running, the same write changes only the buffer.
- R8: A read of address 0 returns the live count. A read of address 1 returns {run, flag, 3'b000, select}.
- R9: The flag (control bit 6) stays set until a control write puts 0 in bit 6. Writing 1 there has no effect. An underflow in the same cycle as a clearing write leaves the flag set.
- R10: Writing 0 to the run bit stops counting, and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 2 | Register address (0 count/buffer, 1 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_en | input | 1 | Timer interrupt enable |
| irq | output | 1 | One-cycle underflow interrupt request |

## Verification
The assertions assume that at most one register is written per cycle and that the strobe, address and data are stable around each clock edge. The bench meets this by driving every bus signal on the falling edge and holding it for a single rising edge. The reload check compares against the buffer as it stood before the underflow edge. For that reason the directed scenarios never write the buffer on the same edge as an underflow, except where a test targets that ordering. Tests that clear the flag while the timer runs choose a buffer of zero at divide-by-one. This forces an underflow on every edge, so a clearing write always meets a hardware set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int DATA_W    = 8;
    parameter int ADDR_W    = 2;
    parameter int SEL_W     = 3;
    parameter int MAX_SHIFT = 4;

    localparam logic [ADDR_W-1:0] ADR_COUNT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(1);

    localparam int RUN_BIT  = DATA_W - 1;
    localparam int FLAG_BIT = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] pre;
        logic              run;
        logic              flag;
        logic [SEL_W-1:0]  sel;
    } regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              irq;
    } core_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W     = tmr_pkg::SEL_W,
    parameter int MAX_SHIFT = tmr_pkg::MAX_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int SH_W = $clog2(MAX_SHIFT + 1);

    logic [MAX_SHIFT-1:0] div_d, div_q;
    logic [MAX_SHIFT-1:0] mask;
    logic [SH_W-1:0]      shift;

    always_comb begin
        if (sel[SEL_W-1]) shift = SH_W'(MAX_SHIFT);
        else              shift = SH_W'(sel[SEL_W-2:0]);
        for (int i = 0; i < MAX_SHIFT; i++) begin
            mask[i] = (i < int'(shift));
        end
        tick  = run && ((div_q & mask) == mask);
        // Held at zero while stopped, so a start begins a full period.
        div_d = run ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uflow,
    input  logic [DATA_W-1:0] live_cnt,
    output logic [DATA_W-1:0] pre_q,
    output logic              run_q,
    output logic              flag_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              start,
    output logic              direct,
    output logic [DATA_W-1:0] rdata
);
    regs_t r_d, r_q;
    logic  wr_cnt, wr_ctl;

    always_comb begin
        wr_cnt = wr && (addr == ADR_COUNT);
        wr_ctl = wr && (addr == ADR_CTRL);
        r_d    = r_q;
        if (wr_cnt) r_d.pre = wdata;
        if (wr_ctl) begin
            r_d.run = wdata[RUN_BIT];
            r_d.sel = wdata[SEL_W-1:0];
        end
        // Hardware set wins over a software clear in the same cycle.
        r_d.flag = uflow | (r_q.flag & ~(wr_ctl & ~wdata[FLAG_BIT]));
        start    = wr_ctl && wdata[RUN_BIT] && !r_q.run;
        direct   = wr_cnt && !r_q.run;

        rdata = '0;
        if (addr == ADR_COUNT) begin
            rdata = live_cnt;
        end else if (addr == ADR_CTRL) begin
            rdata[RUN_BIT]     = r_q.run;
            rdata[FLAG_BIT]    = r_q.flag;
            rdata[SEL_W-1:0]   = r_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pre_q  = r_q.pre;
    assign run_q  = r_q.run;
    assign flag_q = r_q.flag;
    assign sel_q  = r_q.sel;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              direct,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pre,
    input  logic              irq_en,
    output logic [DATA_W-1:0] cnt_q,
    output logic              uflow,
    output logic              irq_q
);
    core_t c_d, c_q;

    always_comb begin
        c_d   = c_q;
        uflow = tick && (c_q.cnt == '0);
        if (start) begin
            c_d.cnt = pre;
        end else if (direct) begin
            c_d.cnt = wdata;
        end else if (tick) begin
            c_d.cnt = uflow ? pre : c_q.cnt - 1'b1;
        end
        c_d.irq = uflow && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_q = c_q.cnt;
    assign irq_q = c_q.irq;
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    output logic              irq
);
    logic [DATA_W-1:0] pre_w, cnt_w;
    logic              run_w, flag_w, start_w, direct_w, tick_w, uflow_w;
    logic [SEL_W-1:0]  sel_w;

    tmr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .uflow(uflow_w), .live_cnt(cnt_w),
        .pre_q(pre_w), .run_q(run_w), .flag_q(flag_w), .sel_q(sel_w),
        .start(start_w), .direct(direct_w), .rdata(bus_rdata)
    );

    tmr_prescaler #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run_w), .sel(sel_w), .tick(tick_w)
    );

    tmr_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .start(start_w),
        .direct(direct_w), .wdata(bus_wdata), .pre(pre_w),
        .irq_en(irq_en), .cnt_q(cnt_w), .uflow(uflow_w), .irq_q(irq)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              run,
    input logic              flag,
    input logic              tick,
    input logic              irq,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] pre
);
    logic wr_cnt, wr_ctl;
    assign wr_cnt = wr && (addr == ADR_COUNT);
    assign wr_ctl = wr && (addr == ADR_CTRL);

    AST_DEC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick && cnt != '0 |=> cnt == DATA_W'($past(cnt) - 1'b1)); // R2
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run); // R3
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick && cnt == '0 |=> cnt == $past(pre) && flag); // R4
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R5
    AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> cnt == $past(pre)); // R6
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !run && wr_cnt |=> cnt == $past(wdata)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(wr_ctl && !wdata[FLAG_BIT]) |=> flag); // R9
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_cnt && !(wr_ctl && wdata[RUN_BIT]) |=> $stable(cnt)); // R10
endmodule

bind reload_down_timer tmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .run(run_w), .flag(flag_w), .tick(tick_w),
    .irq(irq), .cnt(cnt_w), .pre(pre_w)
);

// File: tb/tb_reload_down_timer.sv
module tb_reload_down_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_en = 1'b0;
    logic       irq;
    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    reload_down_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(2'd0, v); check("R1 count", v, 8'h00);
        rd_reg(2'd1, v); check("R1 control", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_direct_write();
        logic [7:0] v;
        wr_reg(2'd0, 8'h5A);
        rd_reg(2'd0, v); check("R7 stopped write sets count", v, 8'h5A);
        repeat (5) @(negedge clk);
        rd_reg(2'd0, v); check("R10 stopped count holds", v, 8'h5A);
    endtask

    task automatic t_prescale();
        logic [7:0] v;
        for (int s = 0; s < 8; s++) begin
            int n, k;
            n = (s >= 4) ? 16 : (1 << s);
            wr_reg(2'd1, 8'h00);
            wr_reg(2'd0, 8'h03);
            wr_reg(2'd1, 8'h80 | 8'(s));
            rd_reg(2'd1, v); check("R8 control readback", v, 8'h80 | 8'(s));
            k = 0;
            rd_reg(2'd0, v);
            while (v == 8'h03 && k < 40) begin
                @(negedge clk); k++;
                rd_reg(2'd0, v);
            end
            check("R3 first tick delay", 8'(k), 8'(n));
            check("R2 one step", v, 8'h02);
        end
    endtask

    task automatic t_start_load();
        logic [7:0] v;
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h09);
        wr_reg(2'd1, 8'h84);
        wr_reg(2'd0, 8'h40);
        rd_reg(2'd0, v); check("R7 running write leaves count", v, 8'h09);
        wr_reg(2'd1, 8'h04);
        repeat (20) @(negedge clk);
        rd_reg(2'd0, v); check("R10 stop holds count", v, 8'h09);
        wr_reg(2'd1, 8'h84);
        rd_reg(2'd0, v); check("R6 start loads buffer", v, 8'h40);
        wr_reg(2'd1, 8'h00);
    endtask

    task automatic t_underflow();
        logic [7:0] v;
        irq_en = 1'b1;
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h02);
        wr_reg(2'd1, 8'h80);          // count 2
        wr_reg(2'd0, 8'h05);          // count 1, buffer 5
        rd_reg(2'd0, v); check("R2 count 1", v, 8'h01);
        @(negedge clk);
        rd_reg(2'd0, v); check("R2 count 0", v, 8'h00);
        check("R5 no irq before underflow", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rd_reg(2'd0, v); check("R4 reload new buffer", v, 8'h05);
        rd_reg(2'd1, v); check("R4 flag set", v, 8'hC0);
        check("R5 irq pulse", {7'd0, irq}, 8'h01);
        @(negedge clk);
        check("R5 irq one cycle", {7'd0, irq}, 8'h00);
        rd_reg(2'd0, v); check("R2 after reload", v, 8'h04);
    endtask

    task automatic t_flag_and_irq();
        logic [7:0] v;
        int cnt_irq;
        wr_reg(2'd1, 8'hC0);          // writing 1 to the flag: no change
        rd_reg(2'd1, v); check("R9 write one keeps flag", v, 8'hC0);
        wr_reg(2'd1, 8'h40);          // stop, flag untouched
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, v); check("R9 flag cleared", v, 8'h00);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h80);          // underflow every cycle from now on
        wr_reg(2'd1, 8'h80);          // clear meets hardware set
        rd_reg(2'd1, v); check("R9 set wins over clear", v, 8'hC0);
        irq_en = 1'b0;
        @(negedge clk);
        cnt_irq = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt_irq += int'(irq); end
        check("R5 masked irq", 8'(cnt_irq), 8'd0);
        irq_en = 1'b1;
        @(negedge clk);
        cnt_irq = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt_irq += int'(irq); end
        check("R5 irq each underflow", 8'(cnt_irq), 8'd8);
        wr_reg(2'd1, 8'h40);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_write();
        t_prescale();
        t_start_load();
        t_underflow();
        t_flag_and_irq();
        finish_run();
    end
endmodule